// File: doc/BRIEF.md
# Toggle Bit Completion Poller

This block sits on the host side of a byte-wide flash device. It decides when an embedded program or erase operation has finished. Once started, it reads the device status byte over a request/ready read handshake. It compares status bit 6 across two consecutive reads, and a bit that holds its value means the operation is complete. While bit 6 keeps changing, the block also looks at status bit 5, the device's timeout flag. With the flag low it keeps issuing fresh read pairs. With the flag high it makes one more read pair, because the toggle bit may have stopped at the same moment the flag rose. Only then does it report success or failure.

On failure the block raises a sticky error flag. It then writes a configurable reset command byte to the device, so that the device returns to array reads. An optional iteration limit forces the failure path when the toggle bit never settles and the timeout flag never rises. An abort input abandons polling at any point. The next start always begins again with a fresh pair of reads.

Top module: `toggle_poller`

## Requirements
- R1: After reset, busReq, busWe, busy, doneOk, doneFail and errSticky are all 0.
- R2: A start accepted while idle issues two reads (busReq=1, busWe=0). If bit 6 of the second status byte equals bit 6 of the first, doneOk pulses for one cycle and no write is issued.
- R3: If bit 6 differs within a pair and bit 5 of the second byte is 0, the block issues a new pair of reads and compares only within that new pair.
- R4: If bit 6 differs and bit 5 of the second byte is 1, the block issues exactly one more read pair. If bit 6 matches within that pair, doneOk pulses.
- R5: If that recheck pair still differs in bit 6, doneFail pulses and errSticky becomes 1. Exactly one write (busWe=1) of data RST_CMD (default 8'hF0) follows, and then the block goes idle.
- R6: errSticky stays 1 until the next accepted start, which clears it.
- R7: With MAX_ITER>0 (default 8), MAX_ITER consecutive differing pairs with bit 5 low take the R5 failure path: doneFail, errSticky and one reset write, after 2*MAX_ITER reads.
- R8: abort returns the block to idle on the next edge with no done pulse and no write. A later start begins with the first read of a fresh pair, and only two reads are needed when that pair matches.
- R9: busReq, busWe and busWdata are held stable until busReady is sampled high. A read byte is consumed only on a cycle with busReq and busReady both high.
- R10: start is ignored while busy is 1. When abort and start are high together while idle, the block stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a polling run (taken only when idle) |
| abort | input | 1 | Abandon polling and go idle |
| busReq | output | 1 | Bus transaction request |
| busWe | output | 1 | 1 = write (reset command), 0 = status read |
| busWdata | output | 8 | Write data, RST_CMD during the reset write |
| busReady | input | 1 | Transaction accepted this cycle |
| busRdata | input | 8 | Status byte returned on an accepted read |
| busy | output | 1 | Polling or reset write in progress |
| doneOk | output | 1 | One-cycle pulse: operation completed |
| doneFail | output | 1 | One-cycle pulse: operation failed |
| errSticky | output | 1 | Failure flag held until the next start |

## Verification
A wrong stored toggle value shows up in the read count before completion. The poller stops after the wrong number of reads, or it reports success where a failure was due. The bench therefore counts accepted reads and writes for every scenario. A state machine stuck or misrouted after abort, after a timeout flag, or at the iteration limit shows at the ports within one or two handshakes, as a missing or extra reset write, a wrong done pulse, or busy staying high. The stalled-ready scenario shows whether the request is held and whether a byte is consumed without the handshake.

// File: rtl/toggle_poller_pkg.sv
package toggle_poller_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RD_A,
    S_RD_B,
    S_RECHK_A,
    S_RECHK_B,
    S_RST_WR
  } pollState_t;

  typedef struct packed {
    logic clrRun;   // new run accepted
    logic capPrev;  // store bit 6 of current read
    logic incIter;  // count a toggling pair with timeout flag low
    logic setOk;    // completion seen
    logic setFail;  // failure decided
  } pollStb_t;

  localparam int TOGGLE_BIT  = 6;
  localparam int TIMEOUT_BIT = 5;

endpackage

// File: rtl/toggle_poller_dp.sv
module toggle_poller_dp
  import toggle_poller_pkg::*;
#(
  parameter int MAX_ITER = 8
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start,
  input  pollStb_t stb,
  input  logic     curBit,
  output logic     prevBit,
  output logic     iterHit,
  output logic     doneOk,
  output logic     doneFail,
  output logic     errSticky
);

  localparam int ITER_W = (MAX_ITER > 1) ? $clog2(MAX_ITER) : 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prevBit   <= 1'b0;
      doneOk    <= 1'b0;
      doneFail  <= 1'b0;
      errSticky <= 1'b0;
    end else begin
      doneOk   <= stb.setOk;
      doneFail <= stb.setFail;
      if (stb.capPrev) prevBit <= curBit;
      if (stb.clrRun)       errSticky <= 1'b0;
      else if (stb.setFail) errSticky <= 1'b1;
    end
  end

  generate
    if (MAX_ITER > 0) begin : g_iter
      logic [ITER_W-1:0] iterCnt;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           iterCnt <= '0;
        else if (stb.clrRun)  iterCnt <= '0;
        else if (stb.incIter) iterCnt <= iterCnt + 1'b1;
      end
      assign iterHit = (iterCnt == ITER_W'(MAX_ITER - 1));

      // R7
      iter_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iterCnt <= ITER_W'(MAX_ITER - 1));
    end else begin : g_noiter
      assign iterHit = 1'b0;
    end
  endgenerate

  // R6
  sticky_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(errSticky) |-> $past(start));

  // R2
  done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(doneOk && doneFail));

endmodule

// File: rtl/toggle_poller_ctrl.sv
module toggle_poller_ctrl
  import toggle_poller_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       abort,
  input  logic       busReady,
  input  logic [7:0] busRdata,
  input  logic       prevBit,
  input  logic       iterHit,
  output pollStb_t   stb,
  output logic       busReq,
  output logic       busWe,
  output logic       busy
);

  pollState_t state, nextState;

  logic sameBit;
  assign sameBit = (busRdata[TOGGLE_BIT] == prevBit);

  always_comb begin
    nextState = state;
    stb       = '0;
    if (abort) begin
      nextState = S_IDLE;
    end else begin
      unique case (state)
        S_IDLE: if (start) begin
          stb.clrRun = 1'b1;
          nextState  = S_RD_A;
        end
        S_RD_A: if (busReady) begin
          stb.capPrev = 1'b1;
          nextState   = S_RD_B;
        end
        S_RD_B: if (busReady) begin
          if (sameBit) begin
            stb.setOk = 1'b1;
            nextState = S_IDLE;
          end else if (busRdata[TIMEOUT_BIT]) begin
            nextState = S_RECHK_A;
          end else if (iterHit) begin
            stb.setFail = 1'b1;
            nextState   = S_RST_WR;
          end else begin
            stb.incIter = 1'b1;
            nextState   = S_RD_A;
          end
        end
        S_RECHK_A: if (busReady) begin
          stb.capPrev = 1'b1;
          nextState   = S_RECHK_B;
        end
        S_RECHK_B: if (busReady) begin
          if (sameBit) begin
            stb.setOk = 1'b1;
            nextState = S_IDLE;
          end else begin
            stb.setFail = 1'b1;
            nextState   = S_RST_WR;
          end
        end
        S_RST_WR: if (busReady) nextState = S_IDLE;
        default: nextState = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= S_IDLE;
    else        state <= nextState;
  end

  assign busReq = (state != S_IDLE);
  assign busWe  = (state == S_RST_WR);
  assign busy   = (state != S_IDLE);

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busReq && !busReady && !abort) |=> (busReq && $stable(busWe)));

  // R8
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !busy);

endmodule

// File: rtl/toggle_poller.sv
module toggle_poller
  import toggle_poller_pkg::*;
#(
  parameter int         MAX_ITER = 8,
  parameter logic [7:0] RST_CMD  = 8'hF0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       abort,
  output logic       busReq,
  output logic       busWe,
  output logic [7:0] busWdata,
  input  logic       busReady,
  input  logic [7:0] busRdata,
  output logic       busy,
  output logic       doneOk,
  output logic       doneFail,
  output logic       errSticky
);

  pollStb_t stb;
  logic     prevBit;
  logic     iterHit;

  toggle_poller_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .abort    (abort),
    .busReady (busReady),
    .busRdata (busRdata),
    .prevBit  (prevBit),
    .iterHit  (iterHit),
    .stb      (stb),
    .busReq   (busReq),
    .busWe    (busWe),
    .busy     (busy)
  );

  toggle_poller_dp #(.MAX_ITER(MAX_ITER)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .stb       (stb),
    .curBit    (busRdata[TOGGLE_BIT]),
    .prevBit   (prevBit),
    .iterHit   (iterHit),
    .doneOk    (doneOk),
    .doneFail  (doneFail),
    .errSticky (errSticky)
  );

  assign busWdata = busWe ? RST_CMD : 8'h00;

  // R5
  fail_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    doneFail |-> (busReq && busWe));

endmodule

// File: tb/toggle_poller_tb.sv
`timescale 1ns/1ps
module toggle_poller_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       abort = 1'b0;
  logic       busReq, busWe, busy, doneOk, doneFail, errSticky;
  logic [7:0] busWdata;
  logic       readyEn = 1'b1;
  logic [7:0] seq [0:31];
  int         rdCnt = 0, wrCnt = 0, okCnt = 0, failCnt = 0;
  int         base = 0;
  logic [7:0] lastWr = 8'h00;
  int         nChecks = 0, nFails = 0;
  logic       busReady;
  logic [7:0] busRdata;
  int         rdIdx;

  always #2 clk = ~clk;

  assign rdIdx    = rdCnt - base;
  assign busReady = readyEn;
  assign busRdata = seq[rdIdx[4:0]];

  toggle_poller u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
    .busReq(busReq), .busWe(busWe), .busWdata(busWdata),
    .busReady(busReady), .busRdata(busRdata), .busy(busy),
    .doneOk(doneOk), .doneFail(doneFail), .errSticky(errSticky)
  );

  always @(posedge clk) begin
    if (busReq && busReady && !busWe) rdCnt <= rdCnt + 1;
    if (busReq && busReady && busWe) begin
      wrCnt  <= wrCnt + 1;
      lastWr <= busWdata;
    end
    if (doneOk)   okCnt   <= okCnt + 1;
    if (doneFail) failCnt <= failCnt + 1;
  end

  task automatic check(input logic cond, input string tag, input int act, input int exp);
    nChecks++;
    if (!cond) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic fillToggle();
    for (int i = 0; i < 32; i++) seq[i] = (i % 2) ? 8'h40 : 8'h00;
  endtask

  // pulse start, wait until idle, settle counters
  task automatic runPoll(output int reads, output int writes, output int oks, output int fails);
    int r0, w0, o0, f0, guard;
    base = rdCnt;
    r0 = rdCnt; w0 = wrCnt; o0 = okCnt; f0 = failCnt;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    guard = 0;
    while (busy && guard < 500) begin @(negedge clk); guard++; end
    if (guard >= 500) check(1'b0, "watchdog run", guard, 0);
    @(negedge clk);
    reads = rdCnt - r0; writes = wrCnt - w0; oks = okCnt - o0; fails = failCnt - f0;
  endtask

  task automatic t_reset();
    check(!busReq && !busWe && !busy, "R1 bus idle", busReq, 0);
    check(!doneOk && !doneFail && !errSticky, "R1 flags", errSticky, 0);
  endtask

  task automatic t_quiet();
    int r, w, o, f;
    seq[0] = 8'h40; seq[1] = 8'h40;
    runPoll(r, w, o, f);
    check(r == 2, "R2 reads", r, 2);
    check(o == 1 && f == 0, "R2 ok pulse", o, 1);
    check(w == 0, "R2 no write", w, 0);
  endtask

  task automatic t_morePairs();
    int r, w, o, f;
    seq[0] = 8'h00; seq[1] = 8'h40; seq[2] = 8'h00; seq[3] = 8'h40;
    seq[4] = 8'h40; seq[5] = 8'h40;
    runPoll(r, w, o, f);
    check(r == 6, "R3 reads", r, 6);
    check(o == 1 && w == 0, "R3 ok", o, 1);
  endtask

  task automatic t_recheckOk();
    int r, w, o, f;
    seq[0] = 8'h00; seq[1] = 8'h60; seq[2] = 8'h20; seq[3] = 8'h20;
    runPoll(r, w, o, f);
    check(r == 4, "R4 reads", r, 4);
    check(o == 1 && f == 0 && w == 0, "R4 ok", o, 1);
  endtask

  task automatic t_recheckFail();
    int r, w, o, f;
    seq[0] = 8'h00; seq[1] = 8'h60; seq[2] = 8'h20; seq[3] = 8'h60;
    runPoll(r, w, o, f);
    check(r == 4, "R5 reads", r, 4);
    check(f == 1 && o == 0, "R5 fail pulse", f, 1);
    check(w == 1, "R5 one write", w, 1);
    check(lastWr == 8'hF0, "R5 write data", lastWr, 8'hF0);
    check(errSticky && !busy, "R5 sticky idle", errSticky, 1);
  endtask

  task automatic t_stickyClear();
    int r, w, o, f;
    repeat (3) @(negedge clk);
    check(errSticky, "R6 held", errSticky, 1);
    seq[0] = 8'h00; seq[1] = 8'h00;
    runPoll(r, w, o, f);
    check(!errSticky && o == 1, "R6 cleared", errSticky, 0);
  endtask

  task automatic t_iterLimit();
    int r, w, o, f;
    fillToggle();
    runPoll(r, w, o, f);
    check(r == 16, "R7 reads", r, 16);
    check(f == 1 && w == 1 && errSticky, "R7 fail", f, 1);
  endtask

  task automatic t_abort();
    int r, w, o, f, w0, o0, f0;
    fillToggle();
    base = rdCnt; w0 = wrCnt; o0 = okCnt; f0 = failCnt;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (4) @(negedge clk);
    abort = 1'b1;
    @(negedge clk); abort = 1'b0;
    check(!busy && !busReq, "R8 idle after abort", busy, 0);
    repeat (2) @(negedge clk);
    check(wrCnt == w0 && okCnt == o0 && failCnt == f0, "R8 silent", wrCnt - w0, 0);
    seq[0] = 8'h00; seq[1] = 8'h00;
    runPoll(r, w, o, f);
    check(r == 2 && o == 1, "R8 fresh pair", r, 2);
  endtask

  task automatic t_stall();
    int r, w, o, f, r0;
    seq[0] = 8'h40; seq[1] = 8'h40;
    readyEn = 1'b0;
    base = rdCnt; r0 = rdCnt;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int i = 0; i < 5; i++) begin
      check(busReq && !busWe && busy, "R9 req held", busReq, 1);
      if (i == 2) start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    check(rdCnt == r0, "R9 nothing consumed", rdCnt - r0, 0);
    readyEn = 1'b1;
    while (busy) @(negedge clk);
    @(negedge clk);
    check(rdCnt - r0 == 2, "R10 start ignored while busy", rdCnt - r0, 2);
  endtask

  task automatic t_abortBeatsStart();
    @(negedge clk); start = 1'b1; abort = 1'b1;
    @(negedge clk); start = 1'b0; abort = 1'b0;
    check(!busy && !busReq, "R10 abort wins", busy, 0);
  endtask

  initial begin
    #(200000 * 4);
    nFails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks + 1, nFails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) seq[i] = 8'h00;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_quiet();
    t_morePairs();
    t_recheckOk();
    t_recheckFail();
    t_stickyClear();
    t_iterLimit();
    t_abort();
    t_stall();
    t_abortBeatsStart();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule